// File: doc/BRIEF.md
# Inter-Processor Signal Interrupt Controller

This block is the receive-and-send point for numbered doorbell signals between processors. A local processor raises a signal toward a peer by writing a packed client/signal identifier to a send register. The block then emits a one-cycle pulse tagged with that client and signal toward the interconnect. In the other direction, peers deliver set pulses tagged with a client and signal. Each (client, signal) pair has a pending bit and an enable bit.

Software does not handle bitmasks. Every control register takes one packed identifier as write data: the client number in the upper half-word and the signal number in the lower half-word. A read-only identifier register returns the next source that is both pending and enabled, or the all-ones value when none is. A single active-high level interrupt stays up while any such source exists. An interrupt handler therefore loops: read the identifier, clear that source, service it, and stop when the all-ones value comes back.

The number of clients and the number of signals per client are small parameters. The flat source index of a pair is client × signal count + signal.

Top module: `sigirq_ctrl`

## Requirements
- R1: An identifier is 32 bits wide, with the client number in bits [31:16] and the signal number in bits [15:0]. All identifier-carrying registers use this format.
- R2: A write to offset 0x0C produces, on the cycle after the write, a one-cycle `out_send_vld` pulse. The pulse carries the written client on `out_send_client` and the written signal on `out_send_signal`.
- R3: A read of offset 0x10 returns the identifier of a source that is both pending and enabled. When there is no such source, the read returns 0xFFFFFFFF.
- R4: A write to offset 0x14 sets the enable bit of the identified source, and a write to offset 0x18 clears it. No other source's enable bit changes.
- R5: A write to offset 0x1C clears the pending bit of the identified source only.
- R6: `irq_out` is high exactly when at least one source is both pending and enabled.
- R7: A write to offset 0x38 clears every pending bit whose client equals bits [31:16] of the write data. Bits [15:0] are not used.
- R8: When several sources qualify, offset 0x10 reports the lowest client first, and within that client the lowest signal.
- R9: An incoming set pulse marks its source pending even while the source is disabled. The source becomes visible at offset 0x10 and on `irq_out` as soon as it is enabled.
- R10: A set pulse and a clear of the same source in the same cycle leave that source pending.
- R11: After reset, all pending and enable bits are zero. Unmapped offsets read as zero, and writes to them change nothing.
- R12: A write whose client or signal number is out of range has no effect at any identifier offset, including the send offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data (identifier) |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_rdata | output | 32 | Read data, zero when no read is in progress |
| in_set_vld | input | 1 | Incoming signal set pulse |
| in_set_client | input | CW | Client of the incoming pulse |
| in_set_signal | input | SW | Signal of the incoming pulse |
| out_send_vld | output | 1 | Outgoing send pulse |
| out_send_client | output | 16 | Client of the outgoing pulse |
| out_send_signal | output | 16 | Signal of the outgoing pulse |
| irq_out | output | 1 | Level summary interrupt |

## Verification
The hardest case to bring about from the ports is an incoming set pulse that lands in the same clock edge as a software clear of the same source. It needs the bus write strobe and the set input to be raised on the same falling edge. A dedicated task drives both together, then reads the identifier register to prove the source survived. A second case the bench builds deliberately is a write whose signal number is one past the last valid signal. Without a range check, that number would alias onto signal 0 of the next client, so the bench keeps that neighbour pending and enabled and watches that it stays reported.

// File: rtl/sigirq_pkg.sv
package sigirq_pkg;

  localparam int unsigned ADDR_W = 8;
  localparam logic [31:0] NO_SOURCE = 32'hFFFF_FFFF;

  localparam logic [ADDR_W-1:0] OFS_SEND  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_NEXT  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_ENA   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_DIS   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_CCLR  = 8'h38;

  // client in the upper half-word, signal in the lower
  function automatic logic [31:0] make_id(input logic [15:0] c, input logic [15:0] s);
    return {c, s};
  endfunction

  function automatic logic id_in_range(input logic [31:0] id,
                                       input int unsigned nc, input int unsigned ns);
    return (32'(id[31:16]) < nc) && (32'(id[15:0]) < ns);
  endfunction

  function automatic logic [31:0] flat_index(input logic [31:0] id, input int unsigned ns);
    return 32'(id[31:16]) * ns + 32'(id[15:0]);
  endfunction

  function automatic logic [31:0] id_of_index(input logic [31:0] idx, input int unsigned ns);
    return make_id(16'(idx / ns), 16'(idx % ns));
  endfunction

endpackage

// File: rtl/sigirq_regif.sv
module sigirq_regif
  import sigirq_pkg::*;
#(
  parameter int unsigned NC   = 4,
  parameter int unsigned NS   = 8,
  localparam int unsigned NSRC = NC * NS,
  localparam int unsigned IW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              pick_vld,
  input  logic [IW-1:0]     pick_idx,
  output logic              send_ev,
  output logic [31:0]       send_id,
  output logic [NSRC-1:0]   en_set_mask,
  output logic [NSRC-1:0]   en_clr_mask,
  output logic [NSRC-1:0]   clr_mask
);

  logic id_ok, cl_ok;
  logic hit_send, hit_ena, hit_dis, hit_clr, hit_cclr;
  logic [NSRC-1:0] sel_mask, cl_mask;

  assign id_ok = id_in_range(bus_wdata, NC, NS);
  assign cl_ok = 32'(bus_wdata[31:16]) < NC;

  assign hit_send = bus_wr && (bus_addr == OFS_SEND);
  assign hit_ena  = bus_wr && (bus_addr == OFS_ENA);
  assign hit_dis  = bus_wr && (bus_addr == OFS_DIS);
  assign hit_clr  = bus_wr && (bus_addr == OFS_CLR);
  assign hit_cclr = bus_wr && (bus_addr == OFS_CCLR);

  for (genvar i = 0; i < NSRC; i++) begin : g_sel
    assign sel_mask[i] = id_ok && (flat_index(bus_wdata, NS) == 32'(i));
    assign cl_mask[i]  = cl_ok && (32'(bus_wdata[31:16]) == 32'(i / NS));
  end

  assign en_set_mask = hit_ena ? sel_mask : '0;
  assign en_clr_mask = hit_dis ? sel_mask : '0;
  assign clr_mask    = (hit_clr ? sel_mask : '0) | (hit_cclr ? cl_mask : '0);

  assign send_ev = hit_send && id_ok;
  assign send_id = bus_wdata;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && (bus_addr == OFS_NEXT))
      bus_rdata = pick_vld ? id_of_index(32'(pick_idx), NS) : NO_SOURCE;
  end

endmodule

// File: rtl/sigirq_src_array.sv
module sigirq_src_array
  import sigirq_pkg::*;
#(
  parameter int unsigned NC   = 4,
  parameter int unsigned NS   = 8,
  localparam int unsigned NSRC = NC * NS,
  localparam int unsigned CW   = (NC > 1) ? $clog2(NC) : 1,
  localparam int unsigned SW   = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_vld,
  input  logic [CW-1:0]   set_client,
  input  logic [SW-1:0]   set_signal,
  input  logic [NSRC-1:0] en_set_mask,
  input  logic [NSRC-1:0] en_clr_mask,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] active,
  output logic            irq
);

  logic [31:0]     set_id;
  logic            set_ok;
  logic [NSRC-1:0] set_mask, pend, ena;

  assign set_id = make_id(16'(set_client), 16'(set_signal));
  assign set_ok = set_vld && id_in_range(set_id, NC, NS);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign set_mask[i] = set_ok && (flat_index(set_id, NS) == 32'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[i] <= 1'b0;
        ena[i]  <= 1'b0;
      end else begin
        pend[i] <= (pend[i] && !clr_mask[i]) || set_mask[i];
        ena[i]  <= (ena[i] || en_set_mask[i]) && !en_clr_mask[i];
      end
    end

    // set wins over a clear in the same cycle
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_mask[i] |=> pend[i]);
    assert_clear_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[i] && !set_mask[i]) |=> !pend[i]);
    assert_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      en_set_mask[i] |=> ena[i]);
    assert_disable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      en_clr_mask[i] |=> !ena[i]);
    assert_pend_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_mask[i] && !clr_mask[i]) |=> $stable(pend[i]));
  end

  assign active = pend & ena;
  assign irq    = |active;

endmodule

// File: rtl/sigirq_pick.sv
module sigirq_pick #(
  parameter int unsigned NSRC = 32,
  localparam int unsigned IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] active,
  output logic            pick_vld,
  output logic [IW-1:0]   pick_idx
);

  // scan from the top so the lowest index is the last to win
  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (active[i]) begin
        pick_vld = 1'b1;
        pick_idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/sigirq_ctrl.sv
module sigirq_ctrl
  import sigirq_pkg::*;
#(
  parameter int unsigned NC   = 4,
  parameter int unsigned NS   = 8,
  localparam int unsigned NSRC = NC * NS,
  localparam int unsigned IW   = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int unsigned CW   = (NC > 1) ? $clog2(NC) : 1,
  localparam int unsigned SW   = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              in_set_vld,
  input  logic [CW-1:0]     in_set_client,
  input  logic [SW-1:0]     in_set_signal,
  output logic              out_send_vld,
  output logic [15:0]       out_send_client,
  output logic [15:0]       out_send_signal,
  output logic              irq_out
);

  logic            send_ev;
  logic [31:0]     send_id;
  logic [NSRC-1:0] en_set_mask, en_clr_mask, clr_mask, active;
  logic            pick_vld, any_active;
  logic [IW-1:0]   pick_idx;

  sigirq_regif #(.NC(NC), .NS(NS)) u_regif (
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pick_vld(pick_vld), .pick_idx(pick_idx),
    .send_ev(send_ev), .send_id(send_id),
    .en_set_mask(en_set_mask), .en_clr_mask(en_clr_mask), .clr_mask(clr_mask)
  );

  sigirq_src_array #(.NC(NC), .NS(NS)) u_array (
    .clk(clk), .rst_n(rst_n),
    .set_vld(in_set_vld), .set_client(in_set_client), .set_signal(in_set_signal),
    .en_set_mask(en_set_mask), .en_clr_mask(en_clr_mask), .clr_mask(clr_mask),
    .active(active), .irq(any_active)
  );

  sigirq_pick #(.NSRC(NSRC)) u_pick (
    .active(active), .pick_vld(pick_vld), .pick_idx(pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_send_vld    <= 1'b0;
      out_send_client <= '0;
      out_send_signal <= '0;
    end else begin
      out_send_vld <= send_ev;
      if (send_ev) begin
        out_send_client <= send_id[31:16];
        out_send_signal <= send_id[15:0];
      end
    end
  end

  assign irq_out = any_active;

  assert_send_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    send_ev |=> (out_send_vld && out_send_client == $past(send_id[31:16])
                 && out_send_signal == $past(send_id[15:0])));
  assert_send_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !send_ev |=> !out_send_vld);
  assert_irq_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == pick_vld);
  assert_pick_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld |-> (active[pick_idx] &&
                  ((active & ((NSRC'(1) << pick_idx) - NSRC'(1))) == '0)));

endmodule

// File: tb/sigirq_ctrl_test.sv
module sigirq_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        in_set_vld = 1'b0;
  logic [1:0]  in_set_client = '0;
  logic [2:0]  in_set_signal = '0;
  logic        out_send_vld;
  logic [15:0] out_send_client, out_send_signal;
  logic        irq_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  bit mpend [NC][NS];
  bit mena  [NC][NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  sigirq_ctrl #(.NC(NC), .NS(NS)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .in_set_vld(in_set_vld), .in_set_client(in_set_client),
    .in_set_signal(in_set_signal), .out_send_vld(out_send_vld),
    .out_send_client(out_send_client), .out_send_signal(out_send_signal),
    .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] id(input int c, input int s);
    return {16'(c), 16'(s)};
  endfunction

  function automatic logic [31:0] model_next();
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++)
        if (mpend[c][s] && mena[c][s]) return id(c, s);
    return 32'hFFFF_FFFF;
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic pulse_set(input int c, input int s);
    @(negedge clk);
    in_set_vld = 1'b1; in_set_client = 2'(c); in_set_signal = 3'(s);
    @(negedge clk);
    in_set_vld = 1'b0;
    mpend[c][s] = 1'b1;
  endtask

  task automatic enable(input int c, input int s);
    bus_write(8'h14, id(c, s)); mena[c][s] = 1'b1;
  endtask

  task automatic check_next(input string tag);
    logic [31:0] d;
    bus_read(8'h10, d);
    check(tag, d, model_next());
    check({tag, " irq R6"}, 32'(irq_out), 32'(model_next() != 32'hFFFF_FFFF));
  endtask

  task automatic clear_src(input int c, input int s);
    bus_write(8'h1C, id(c, s)); mpend[c][s] = 1'b0;
  endtask

  task automatic t_reset();
    check_next("R11 reset sentinel R3");
    check("R11 reset send", 32'(out_send_vld), 0);
  endtask

  task automatic t_send();
    bus_write(8'h0C, id(2, 5));
    check("R2 send vld", 32'(out_send_vld), 1);
    check("R2 send client R1", 32'(out_send_client), 2);
    check("R2 send signal R1", 32'(out_send_signal), 5);
    @(negedge clk);
    check("R2 one-cycle", 32'(out_send_vld), 0);
    bus_write(8'h0C, id(7, 0));
    check("R12 send out of range", 32'(out_send_vld), 0);
  endtask

  task automatic t_masked_pending();
    pulse_set(1, 3);
    check_next("R9 disabled pending hidden");
    enable(1, 3);
    check_next("R9 visible after enable R4");
  endtask

  task automatic t_priority();
    pulse_set(3, 0); pulse_set(0, 7); pulse_set(0, 2);
    enable(3, 0); enable(0, 7); enable(0, 2);
    check_next("R8 lowest first (0,2)");
    clear_src(0, 2);
    check_next("R8 then (0,7) R5");
    clear_src(0, 7);
    check_next("R8 then (1,3)");
  endtask

  task automatic t_disable();
    pulse_set(0, 2);
    check_next("R4 (0,2) back");
    bus_write(8'h18, id(0, 2)); mena[0][2] = 1'b0;
    check_next("R4 disabled skips to (1,3)");
    enable(0, 2);
    check_next("R4 reenabled (0,2)");
    clear_src(0, 2);
  endtask

  task automatic t_client_clear();
    pulse_set(2, 1); pulse_set(2, 6);
    enable(2, 1); enable(2, 6);
    clear_src(1, 3);
    check_next("R7 before: (2,1)");
    bus_write(8'h38, id(2, 9));
    mpend[2][1] = 1'b0; mpend[2][6] = 1'b0;
    check_next("R7 client 2 gone, (3,0) left");
  endtask

  task automatic t_collision();
    enable(1, 4);
    @(negedge clk);
    in_set_vld = 1'b1; in_set_client = 2'd1; in_set_signal = 3'd4;
    bus_addr = 8'h1C; bus_wdata = id(1, 4); bus_wr = 1'b1;
    @(negedge clk);
    in_set_vld = 1'b0; bus_wr = 1'b0;
    mpend[1][4] = 1'b1;
    check_next("R10 set wins over clear");
    clear_src(1, 4);
  endtask

  task automatic t_out_of_range();
    pulse_set(1, 0); enable(1, 0);
    check_next("R12 (1,0) ready");
    bus_write(8'h1C, id(0, 8));
    check_next("R12 alias clear ignored");
    bus_write(8'h18, id(0, 8));
    check_next("R12 alias disable ignored");
    bus_write(8'h14, id(4, 0));
    check_next("R12 bad client enable ignored");
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_read(8'h20, d);
    check("R11 unmapped read", d, 0);
    bus_read(8'h1C, d);
    check("R11 write-only reads zero", d, 0);
    bus_write(8'h20, id(1, 0));
    check_next("R11 unmapped write ignored");
    clear_src(1, 0); clear_src(3, 0);
    check_next("R3 all cleared sentinel");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_send();
    t_masked_pending();
    t_priority();
    t_disable();
    t_client_clear();
    t_collision();
    t_out_of_range();
    t_unmapped();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule